// File: doc/BRIEF.md
# Cellular-Automaton Random Word Generator Row with Chained Seed Loading

This block supplies every processing element of one array row with its own private source of random words. Each element holds a W-bit state that advances once per clock under a hybrid one-dimensional cellular automaton. Every cell uses one of two rules. Rule 90 XORs the two adjacent cells. Rule 150 XORs the two adjacent cells and the cell itself. A cell beyond either end of the word reads as 0. A fixed mask parameter chooses the rule for each cell position. No element shares its generator with another, so the genetic operators of each element draw from their own stream.

Seeds come in through a systolic chain. While the load input is high, the first element takes the external seed and each later element takes the value its upstream neighbour held one clock before. After enough capture cycles, every element holds a different seed and a done flag rises. When the load input goes low, every element starts stepping from its own seed. A build-time option changes the chain to take one seed bit per clock, which saves pins. In that variant the whole row behaves as one long shift register. The automaton is never allowed to stay at zero: a zero state is replaced by a nonzero constant in place of a step.

Top module: `ca_rng_row`

## Requirements
- R1: After reset, every element state on `rnd_out` is 0 and `seed_done` is 0.
- R2: With SERIAL=0, on each clock with `load_en` high, element 0 captures `seed_word` and element k (k>0) captures the value element k-1 held before that edge. Feeding 3, 124, 255 on three consecutive captures leaves element 0 at 255, element 1 at 124 and element 2 at 3.
- R3: On each clock with `load_en` low and a nonzero state, the new value of bit i is bit i+1 XOR bit i-1, XORed also with bit i when bit i of RULE150_MASK is 1. Bits beyond position 0 and position W-1 read as 0. The default mask is 8'h69.
- R4: Each element advances only from its own state, so elements with different seeds produce different streams. While `load_en` is high, no element steps its automaton.
- R5: On a clock with `load_en` low, an element whose state is 0 takes ZERO_SUB (default 8'h5A) in place of a step.
- R6: `seed_done` rises after CAPTURES consecutive capture clocks. CAPTURES is DIM with SERIAL=0 and DIM*W with SERIAL=1. `seed_done` goes low after the first capture of a new load burst, and it stays unchanged while the row runs.
- R7: With SERIAL=1, each capture clock shifts every element left by one bit. Element 0 takes `seed_bit` into bit 0, and element k takes the old bit W-1 of element k-1 into bit 0. `seed_word` is ignored in this variant, and `seed_bit` is ignored with SERIAL=0.
- R8: Element k appears on `rnd_out[k*W +: W]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_en | input | 1 | High: capture and shift seeds; low: run the generators |
| seed_word | input | W | Parallel seed entering element 0 |
| seed_bit | input | 1 | Serial seed bit entering element 0 |
| rnd_out | output | DIM*W | Current state of every element, element k at bits k*W |
| seed_done | output | 1 | The row holds a full set of seeds |

## Verification
The zero-replacement path is the hardest state to reach. A nonsingular automaton never steps into zero on its own, so the only way to get there is to load all-zero seeds through the chain and then release `load_en`. The bench does exactly that, and it also cuts a load burst short to check that `seed_done` clears and rises again. Random runs that mix loading and running compare every element on every clock against a model built from R3 and R5. A second instance with the serial chain is driven bit by bit over the same clocks.

// File: rtl/ca_rng_pkg.sv
package ca_rng_pkg;
   // Number of capture clocks needed before every element of the row holds a seed
   function automatic int unsigned capture_cycles(input int unsigned dim,
                                                  input int unsigned w,
                                                  input bit          serial);
      return serial ? dim * w : dim;
   endfunction
endpackage

// File: rtl/ca_rule_step.sv
module ca_rule_step #(
   parameter int unsigned W = 8,
   parameter logic [W-1:0] RULE150_MASK = '0
) (
   input  logic [W-1:0] cur,
   output logic [W-1:0] nxt
);
   // One cell per bit; null boundaries at both ends
   for (genvar i = 0; i < W; i++) begin : g_cell
      logic upper, lower, self_term;
      if (i == W - 1) begin : g_top
         assign upper = 1'b0;
      end else begin : g_top_in
         assign upper = cur[i+1];
      end
      if (i == 0) begin : g_bot
         assign lower = 1'b0;
      end else begin : g_bot_in
         assign lower = cur[i-1];
      end
      if (RULE150_MASK[i]) begin : g_r150
         assign self_term = cur[i];
      end else begin : g_r90
         assign self_term = 1'b0;
      end
      assign nxt[i] = upper ^ lower ^ self_term;
   end
endmodule

// File: rtl/ca_rng_cell.sv
module ca_rng_cell #(
   parameter int unsigned  W            = 8,
   parameter bit           SERIAL       = 1'b0,
   parameter logic [W-1:0] RULE150_MASK = 8'h69,
   parameter logic [W-1:0] ZERO_SUB     = 8'h5A
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_en,
   input  logic [W-1:0] shift_in,
   output logic [W-1:0] shift_out,
   output logic [W-1:0] state
);
   logic [W-1:0] stepped;
   logic [W-1:0] loaded;

   ca_rule_step #(.W(W), .RULE150_MASK(RULE150_MASK)) u_step (
      .cur (state),
      .nxt (stepped)
   );

   if (SERIAL) begin : g_serial
      assign loaded    = {state[W-2:0], shift_in[0]};
      assign shift_out = {{(W-1){1'b0}}, state[W-1]};
   end else begin : g_parallel
      assign loaded    = shift_in;
      assign shift_out = state;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         state <= '0;
      else if (load_en)
         state <= loaded;
      else if (state == '0)
         state <= ZERO_SUB;
      else
         state <= stepped;
   end

   // R5: zero state is replaced by the substitute constant
   assert_zero_sub_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_en && state == '0) |=> (state == ZERO_SUB));

   // R4: during loading the value moves only through the chain input
   if (SERIAL) begin : g_chk_ser
      assert_serial_shift_R7: assert property (@(posedge clk) disable iff (!rst_n)
         load_en |=> (state[W-1:1] == $past(state[W-2:0])));
   end
endmodule

// File: rtl/ca_seed_counter.sv
module ca_seed_counter #(
   parameter int unsigned CAPTURES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_en,
   output logic done
);
   localparam int unsigned CW = $clog2(CAPTURES + 1);
   localparam logic [CW-1:0] LIMIT = CW'(CAPTURES);

   logic [CW-1:0] cnt;
   logic          load_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         load_q <= 1'b0;
      end else begin
         load_q <= load_en;
         if (load_en) begin
            if (!load_q)
               cnt <= CW'(1);
            else if (cnt < LIMIT)
               cnt <= cnt + CW'(1);
         end
      end
   end

   assign done = (cnt == LIMIT);

   // R6: done only rises on a capture clock
   assert_done_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(load_en));
   // R6: done never changes while running
   assert_done_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_en) |=> $stable(done));
   // R6: a new burst clears done unless one capture completes the row
   assert_done_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (load_en && !load_q) |=> (!done || CAPTURES == 1));
endmodule

// File: rtl/ca_rng_row.sv
module ca_rng_row #(
   parameter int unsigned  DIM          = 4,
   parameter int unsigned  W            = 8,
   parameter bit           SERIAL       = 1'b0,
   parameter logic [W-1:0] RULE150_MASK = 8'h69,
   parameter logic [W-1:0] ZERO_SUB     = 8'h5A
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_en,
   input  logic [W-1:0]     seed_word,
   input  logic             seed_bit,
   output logic [DIM*W-1:0] rnd_out,
   output logic             seed_done
);
   import ca_rng_pkg::*;

   localparam int unsigned CAPTURES = capture_cycles(DIM, W, SERIAL);

   // Elaboration-time parameter checks
   if (W < 2) begin : g_bad_w
      $error("ca_rng_row: W must be at least 2");
   end
   if (DIM < 1) begin : g_bad_dim
      $error("ca_rng_row: DIM must be at least 1");
   end
   if (ZERO_SUB == '0) begin : g_bad_sub
      $error("ca_rng_row: ZERO_SUB must be nonzero");
   end

   logic [W-1:0] chain [DIM+1];
   logic [W-1:0] elem  [DIM];

   if (SERIAL) begin : g_head_ser
      assign chain[0] = {{(W-1){1'b0}}, seed_bit};
   end else begin : g_head_par
      assign chain[0] = seed_word;
   end

   for (genvar k = 0; k < DIM; k++) begin : g_elem
      ca_rng_cell #(
         .W(W), .SERIAL(SERIAL),
         .RULE150_MASK(RULE150_MASK), .ZERO_SUB(ZERO_SUB)
      ) u_cell (
         .clk       (clk),
         .rst_n     (rst_n),
         .load_en   (load_en),
         .shift_in  (chain[k]),
         .shift_out (chain[k+1]),
         .state     (elem[k])
      );
      assign rnd_out[k*W +: W] = elem[k];

      if (!SERIAL && k > 0) begin : g_chk_par
         // R2: each capture moves the upstream value one element down
         assert_chain_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
            load_en |=> (elem[k] == $past(elem[k-1])));
      end
      if (SERIAL && k > 0) begin : g_chk_ser
         // R7: the MSB of the upstream element enters bit 0
         assert_bit_link_R7: assert property (@(posedge clk) disable iff (!rst_n)
            load_en |=> (elem[k][0] == $past(elem[k-1][W-1])));
      end
   end

   if (!SERIAL) begin : g_chk_head
      // R2: element 0 captures the external word
      assert_head_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
         load_en |=> (elem[0] == $past(seed_word)));
   end

   ca_seed_counter #(.CAPTURES(CAPTURES)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_en (load_en),
      .done    (seed_done)
   );
endmodule

// File: tb/tb_ca_rng_row.sv
module tb_ca_rng_row;
   localparam int unsigned W    = 8;
   localparam int unsigned DIM  = 4;
   localparam int unsigned DIMS = 2;
   localparam logic [W-1:0] MASK = 8'h69;
   localparam logic [W-1:0] ZS   = 8'h5A;
   localparam int unsigned CAPP = DIM;
   localparam int unsigned CAPS = DIMS * W;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic rst_n = 1'b0, load_en = 1'b0, seed_bit = 1'b0;
   logic [W-1:0] seed_word = '0;
   logic [DIM*W-1:0]  rnd_p;
   logic [DIMS*W-1:0] rnd_s;
   logic done_p, done_s;

   ca_rng_row #(.DIM(DIM), .W(W), .SERIAL(1'b0)) dut (
      .clk(clk), .rst_n(rst_n), .load_en(load_en), .seed_word(seed_word),
      .seed_bit(seed_bit), .rnd_out(rnd_p), .seed_done(done_p));
   ca_rng_row #(.DIM(DIMS), .W(W), .SERIAL(1'b1)) dut_ser (
      .clk(clk), .rst_n(rst_n), .load_en(load_en), .seed_word(seed_word),
      .seed_bit(seed_bit), .rnd_out(rnd_s), .seed_done(done_s));

   logic [W-1:0] mp [DIM];
   logic [W-1:0] ms [DIMS];
   int unsigned cp = 0, cs = 0;
   logic lq = 1'b0;
   int checks = 0, fails = 0;
   bit finished = 1'b0;

   function automatic logic [W-1:0] ca_next(input logic [W-1:0] s);
      logic [W-1:0] n;
      for (int i = 0; i < W; i++) begin
         logic up, dn;
         up = (i < W - 1) ? s[i+1] : 1'b0;
         dn = (i > 0) ? s[i-1] : 1'b0;
         n[i] = up ^ dn ^ (MASK[i] & s[i]);
      end
      return n;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic model_edge();
      if (load_en) begin
         for (int k = DIM - 1; k > 0; k--) mp[k] = mp[k-1];
         mp[0] = seed_word;
         for (int k = DIMS - 1; k > 0; k--) ms[k] = {ms[k][W-2:0], ms[k-1][W-1]};
         ms[0] = {ms[0][W-2:0], seed_bit};
         if (!lq) begin cp = 1; cs = 1; end
         else begin
            if (cp < CAPP) cp++;
            if (cs < CAPS) cs++;
         end
      end else begin
         for (int k = 0; k < DIM; k++) mp[k] = (mp[k] == '0) ? ZS : ca_next(mp[k]);
         for (int k = 0; k < DIMS; k++) ms[k] = (ms[k] == '0) ? ZS : ca_next(ms[k]);
      end
      lq = load_en;
   endtask

   task automatic check_all(input string req);
      for (int k = 0; k < DIM; k++) check(req, 32'(rnd_p[k*W +: W]), 32'(mp[k]));
      for (int k = 0; k < DIMS; k++) check({req, " R7 R8"}, 32'(rnd_s[k*W +: W]), 32'(ms[k]));
      check({req, " R6"}, 32'(done_p), 32'(cp == CAPP));
      check({req, " R6 serial"}, 32'(done_s), 32'(cs == CAPS));
   endtask

   // drive at negedge, model at posedge, compare at following negedge
   task automatic tick(input logic ld, input logic [W-1:0] w, input logic b, input string req);
      load_en = ld; seed_word = w; seed_bit = b;
      @(posedge clk);
      model_edge();
      @(negedge clk);
      check_all(req);
   endtask

   initial begin
      #(20 * 150000);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2024));
      for (int k = 0; k < DIM; k++) mp[k] = '0;
      for (int k = 0; k < DIMS; k++) ms[k] = '0;
      repeat (3) @(negedge clk);
      // R1: reset state
      check_all("R1 reset");
      rst_n = 1'b1;

      // R2: directed sequence 3, 124, 255 (seed_bit toggles, ignored in parallel R7)
      tick(1'b1, 8'd3,   1'b1, "R2 seq");
      tick(1'b1, 8'd124, 1'b0, "R2 seq");
      tick(1'b1, 8'd255, 1'b1, "R2 seq");
      check("R2 elem0", 32'(rnd_p[0 +: W]), 32'd255);
      check("R2 elem1", 32'(rnd_p[W +: W]), 32'd124);
      check("R2 elem2", 32'(rnd_p[2*W +: W]), 32'd3);
      check("R6 not yet done", 32'(done_p), 32'd0);
      tick(1'b1, 8'hC3, 1'b0, "R2 R6 fourth capture");
      check("R6 done after DIM captures", 32'(done_p), 32'd1);

      // R3 R4: run from distinct seeds
      for (int n = 0; n < 40; n++) tick(1'b0, W'($urandom), 1'($urandom), "R3 R4 run");
      check("R4 distinct streams", 32'(rnd_p[0 +: W] != rnd_p[W +: W]), 32'd1);

      // R6: short burst clears done, long burst fills serial chain
      tick(1'b1, 8'h11, 1'b1, "R6 new burst");
      check("R6 cleared", 32'(done_p), 32'd0);
      for (int n = 0; n < 20; n++) tick(1'b1, W'($urandom), 1'($urandom), "R2 R7 load");
      check("R6 serial done", 32'(done_s), 32'd1);

      // R5: all-zero seeds, then release
      for (int n = 0; n < int'(CAPS); n++) tick(1'b1, 8'h00, 1'b0, "R5 zero load");
      tick(1'b0, 8'hFF, 1'b1, "R5 first run");
      check("R5 substitute", 32'(rnd_p[3*W +: W]), 32'(ZS));

      // random mix of load and run bursts
      for (int n = 0; n < 3000; n++) begin
         logic ld;
         ld = ($urandom % 4) == 0;
         tick(ld, W'($urandom), 1'($urandom), "R2 R3 R4 R6 mix");
      end

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule